// File: doc/BRIEF.md
# Shadowed On/Off-Count PWM Generator

This block produces a single pulse-width-modulated output from two cycle counts that software programs through a small memory-mapped register interface with a 32-bit data path. The high phase and the low phase each have their own count of functional-clock cycles. A waveform period is the sum of the two counts. The output is high for the first count and low for the second.

Both counts are written into holding (shadow) registers first. They reach the waveform generator only when the control register is written with its commit bit set. If the generator is idle, the new counts are loaded at once and a fresh period opens with the high phase. If the generator is running, the copy waits for the end of the current period, so no period is ever cut short. The control word also selects whether the generator runs, whether the pin is driven, and whether the waveform is inverted.

Top module: `pwm_shadow_gen`

## Requirements
- R1: Byte address 0x18 holds the low-phase count and 0x1C holds the high-phase count, both 32 bits, and reads of either return the shadow value last written. Any other address except 0x00 reads as zero and ignores writes.
- R2: A read of address 0x00 returns the last control word written, with bit 5 (commit) always reading as zero.
- R3: Writing a count register leaves the running waveform unchanged. A control write with bit 5 clear also commits nothing.
- R4: While the control word is all zero, the output is low.
- R5: The generator runs only when bit 0 (run) and bit 14 (drive) are both set. A running period is HIGH cycles at the active level followed by LOW cycles at the inactive level.
- R6: With a high count of zero the output never reaches the active level. With a low count of zero and a nonzero high count it stays active continuously. With both counts zero it is a flat inactive level.
- R7: A control write with bit 5 set loads both shadow counts into the generator. When idle, the load happens on the next clock and the following cycle is the first high cycle. When running, the load waits until the current period completes.
- R8: Bit 10 inverts the output only while bit 14 is set. With bit 14 clear the output is low. With bit 14 set and the generator not running, the output sits at the inactive level.
- R9: A synchronous active-low reset clears the control word, both shadow counts and both loaded counts, and drives the output low.
- R10: Bit 2 (mode) and bit 9 (trigger) are stored and read back but do not change the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Byte address of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| pwmOut | output | 1 | PWM output pin |

## Verification
The assertions assume that reset is held low for at least one clock edge before any bus activity. They also assume that busAddr and busWrData are stable around the edge on which busWrEn is sampled. The bench drives every input on the falling edge and holds reset over several edges at the start, so both assumptions hold. The assertions also assume that the sum of the two counts fits in 33 bits, which holds for any 32-bit values.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 8'h1C;

  localparam int BIT_RUN    = 0;
  localparam int BIT_MODE   = 2;
  localparam int BIT_COMMIT = 5;
  localparam int BIT_TRIG   = 9;
  localparam int BIT_INV    = 10;
  localparam int BIT_DRIVE  = 14;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic load;
    logic run;
    logic drive;
    logic invert;
  } pwmCtl_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              coreRunning,
  input  logic              boundary,
  output logic [CNT_W-1:0]  shadowHigh,
  output logic [CNT_W-1:0]  shadowLow,
  output logic [DATA_W-1:0] ctrlValue,
  output pwmCtl_t           ctl
);
  localparam logic [DATA_W-1:0] COMMIT_MASK = DATA_W'(1) << BIT_COMMIT;

  logic pending;
  logic wrCtrl, wrHigh, wrLow;

  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
  assign wrHigh = busWrEn && (busAddr == ADDR_HIGH);
  assign wrLow  = busWrEn && (busAddr == ADDR_LOW);

  always_comb begin
    ctl.run    = ctrlValue[BIT_RUN] && ctrlValue[BIT_DRIVE];
    ctl.drive  = ctrlValue[BIT_DRIVE];
    ctl.invert = ctrlValue[BIT_INV];
    ctl.load   = pending && (!coreRunning || boundary);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlValue  <= '0;
      shadowHigh <= '0;
      shadowLow  <= '0;
      pending    <= 1'b0;
    end else begin
      if (ctl.load) pending <= 1'b0;
      if (wrCtrl) begin
        ctrlValue <= busWrData & ~COMMIT_MASK;
        if (busWrData[BIT_COMMIT]) pending <= 1'b1;
      end
      if (wrHigh) shadowHigh <= busWrData[CNT_W-1:0];
      if (wrLow)  shadowLow  <= busWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdData = ctrlValue;
      ADDR_HIGH: busRdData = DATA_W'(shadowHigh);
      ADDR_LOW:  busRdData = DATA_W'(shadowLow);
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_shadow_core.sv
module pwm_shadow_core
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmCtl_t          ctl,
  input  logic [CNT_W-1:0] shadowHigh,
  input  logic [CNT_W-1:0] shadowLow,
  output logic [CNT_W-1:0] activeHigh,
  output logic [CNT_W-1:0] activeLow,
  output logic             boundary,
  output logic             coreRunning,
  output logic             pwmOut
);
  localparam int PER_W = CNT_W + 1;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] phaseCnt;
  logic             wave;

  assign period   = {1'b0, activeHigh} + {1'b0, activeLow};
  assign boundary = (period == '0) || (phaseCnt == period - PER_W'(1));
  assign wave     = coreRunning && ({1'b0, activeHigh} > phaseCnt);
  assign pwmOut   = ctl.drive && (wave ^ ctl.invert);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeHigh  <= '0;
      activeLow   <= '0;
      phaseCnt    <= '0;
      coreRunning <= 1'b0;
    end else begin
      coreRunning <= ctl.run;
      if (ctl.load) begin
        activeHigh <= shadowHigh;
        activeLow  <= shadowLow;
        phaseCnt   <= '0;
      end else if (!ctl.run || !coreRunning || boundary) begin
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              pwmOut
);
  pwmCtl_t           ctlStrobes;
  logic [CNT_W-1:0]  shadowHigh, shadowLow, activeHigh, activeLow;
  logic [DATA_W-1:0] ctrlValue;
  logic              boundary, coreRunning;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .coreRunning(coreRunning), .boundary(boundary),
    .shadowHigh(shadowHigh), .shadowLow(shadowLow),
    .ctrlValue(ctrlValue), .ctl(ctlStrobes)
  );

  pwm_shadow_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobes),
    .shadowHigh(shadowHigh), .shadowLow(shadowLow),
    .activeHigh(activeHigh), .activeLow(activeLow),
    .boundary(boundary), .coreRunning(coreRunning), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwmOut,
  input logic [DATA_W-1:0] ctrlValue,
  input logic [CNT_W-1:0]  activeHigh,
  input logic [CNT_W-1:0]  activeLow,
  input logic              coreRunning,
  input pwmCtl_t           ctlStrobes
);
  a_r4_zero_ctrl_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValue == '0) |-> !pwmOut);

  a_r8_no_drive_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlValue[BIT_DRIVE] |-> !pwmOut);

  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStrobes.load |=> ($stable(activeHigh) && $stable(activeLow)));

  a_r6_zero_high_flat: assert property (@(posedge clk) disable iff (!rstN)
    (coreRunning && ctrlValue[BIT_DRIVE] && activeHigh == '0)
      |-> (pwmOut == ctrlValue[BIT_INV]));

  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> (ctrlValue == '0 && activeHigh == '0 && activeLow == '0 && !pwmOut));
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .ctrlValue(ctrlValue),
  .activeHigh(activeHigh), .activeLow(activeLow),
  .coreRunning(coreRunning), .ctlStrobes(ctlStrobes)
);

// File: tb/pwm_shadow_gen_bench.sv
module pwm_shadow_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pwmOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] RUN = 32'h1, MODE = 32'h4, COMMIT = 32'h20;
  localparam logic [31:0] TRIG = 32'h200, INV = 32'h400, DRV = 32'h4000;

  localparam int NVEC = 8;
  localparam int          V_HI[NVEC]   = '{3, 1, 0, 4, 0, 2, 5, 1};
  localparam int          V_LO[NVEC]   = '{2, 1, 4, 0, 0, 3, 1, 6};
  localparam logic [31:0] V_CTRL[NVEC] = '{RUN|DRV, RUN|DRV, RUN|DRV, RUN|DRV,
                                           RUN|DRV|INV, RUN|DRV|INV,
                                           RUN|DRV|MODE|TRIG, RUN|DRV|INV};

  always #5 clk = ~clk;

  pwm_shadow_gen u_pwm_shadow_gen (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic bit expPin(input int hi, input int lo, input logic [31:0] c, input int k);
    int per = hi + lo;
    bit w = (per != 0) && ((k % (per == 0 ? 1 : per)) < hi);
    return w ^ c[10];
  endfunction

  // counts active samples on the next n falling edges
  task automatic countHigh(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) cnt++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    int cnt;
    int bad;
    int firstBad;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(pwmOut == 1'b0, "R9 pin after reset", {31'b0, pwmOut}, 0);
    rstN = 1'b1;
    busRead(8'h00, rd); check(rd == 0, "R9 ctrl after reset", rd, 0);
    busRead(8'h1C, rd); check(rd == 0, "R9 high count after reset", rd, 0);

    // R1 map and unmapped addresses
    busWrite(8'h18, 32'hCAFE0007);
    busWrite(8'h1C, 32'h12340009);
    busWrite(8'h04, 32'hFFFFFFFF);
    busRead(8'h18, rd); check(rd == 32'hCAFE0007, "R1 low count readback", rd, 32'hCAFE0007);
    busRead(8'h1C, rd); check(rd == 32'h12340009, "R1 high count readback", rd, 32'h12340009);
    busRead(8'h04, rd); check(rd == 0, "R1 unmapped reads zero", rd, 0);

    // R2 commit bit reads zero; R10 mode/trigger stored
    busWrite(8'h00, 32'hFFFFFFFF);
    busRead(8'h00, rd); check(rd == 32'hFFFFFFDF, "R2 ctrl readback", rd, 32'hFFFFFFDF);
    busWrite(8'h00, MODE | TRIG);
    busRead(8'h00, rd); check(rd == (MODE | TRIG), "R10 mode trigger readback", rd, MODE | TRIG);
    busWrite(8'h00, 32'h0);

    // table of waveform vectors (R5 R6 R7 R8 R10)
    for (int v = 0; v < NVEC; v++) begin
      busWrite(8'h00, 32'h0);
      busWrite(8'h1C, V_HI[v]);
      busWrite(8'h18, V_LO[v]);
      busWrite(8'h00, V_CTRL[v] | COMMIT);
      @(posedge clk);
      bad = 0; firstBad = -1;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (pwmOut !== expPin(V_HI[v], V_LO[v], V_CTRL[v], k)) begin
          bad++;
          if (firstBad < 0) firstBad = k;
        end
      end
      check(bad == 0, $sformatf("R5 R6 R7 vector %0d mismatches (first at %0d)", v, firstBad),
            bad, 0);
    end

    // R4 zero control word holds the pin low
    busWrite(8'h00, 32'h0);
    countHigh(10, cnt); check(cnt == 0, "R4 zero ctrl low", cnt, 0);
    // R8 invert without drive stays low
    busWrite(8'h00, RUN | INV);
    countHigh(10, cnt); check(cnt == 0, "R8 invert without drive", cnt, 0);
    // R8 drive+invert but not running: inactive level (high when inverted)
    busWrite(8'h00, DRV | INV);
    countHigh(10, cnt); check(cnt == 10, "R8 R5 drive without run", cnt, 10);

    // R3 shadow hold while running, then R7 commit at boundary
    busWrite(8'h00, 32'h0);
    busWrite(8'h1C, 2);
    busWrite(8'h18, 2);
    busWrite(8'h00, RUN | DRV | COMMIT);
    busWrite(8'h1C, 6);
    busWrite(8'h18, 6);
    countHigh(12, cnt); check(cnt == 6, "R3 counts not committed by count write", cnt, 6);
    busWrite(8'h00, RUN | DRV);
    countHigh(12, cnt); check(cnt == 6, "R3 no commit without bit 5", cnt, 6);
    busWrite(8'h00, RUN | DRV | COMMIT);
    repeat (5) @(negedge clk);
    countHigh(24, cnt); check(cnt == 12, "R7 commit at boundary new period", cnt, 12);

    // R9 reset while running
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(pwmOut == 1'b0, "R9 pin after mid-run reset", {31'b0, pwmOut}, 0);
    busRead(8'h18, rd); check(rd == 0, "R9 low count cleared", rd, 0);
    countHigh(8, cnt); check(cnt == 0, "R9 stays low after reset", cnt, 0);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule